// File: doc/BRIEF.md
# Two-Wire Converter Result Port

This block is the device-side digital end of a converter link that uses only two wires: a serial clock driven by the host and one output that carries both the "result ready" flag and the result bits. A conversion sequencer inside the converter hands it each new 24-bit two's complement result with a one-cycle valid strobe. The block drops the shared output low to announce the result, then shifts the word out, most significant bit first, on the rising edges of the host clock.

The host has no other control path. Commands come only from how many clock pulses it sends and how long it holds the clock high. A 25th rising edge returns the line high. A 26th pulse asks for a self-calibration. A clock held high after the line has gone low puts the converter to sleep. Releasing it wakes the converter, either with a plain conversion restart or, when the 26th pulse was the one held, with a calibration. The block drives sleep, calibration-request and conversion-restart outputs toward the rest of the converter. The host clock is synchronised into the system clock domain. The hold time that means "sleep" is a programmable count of system clocks, long compared with a read pulse.

Top module: `twowire_adc_link`

## Requirements
- R1: After reset the shared output is high, the sleep output is low, and neither the calibration-request nor the restart pulse is asserted.
- R2: A valid strobe while no result is pending loads the result and drives the shared output low on the next system clock.
- R3: Each synchronised rising edge of the host clock puts the next result bit on the shared output, bit 23 first and bit 0 on the 24th edge.
- R4: After the 24th edge the output holds bit 0, and the 25th rising edge drives it high.
- R5: The falling edge that ends the 26th pulse raises the calibration-request output for exactly one system clock, and the output stays high until the next result.
- R6: Once the output has gone low, a host clock that stays high for `sleep_limit` consecutive synchronised system clocks enters sleep, whatever number of bits has been read. The sleep output goes high and the shared output is high throughout sleep.
- R7: A falling host clock edge during sleep clears the sleep output and pulses the restart output for one system clock. The next result then drives the shared output low.
- R8: If the host clock was held into sleep after 26 pulses had been counted, the wake-up pulses the calibration request instead of the restart output.
- R9: A result that arrives before any bit of the current word is shifted, or after all 24 bits, replaces the current word at once.
- R10: A result that arrives after the first bit of a read has been shifted and before the 24th bit (including the cycle of a shifting edge) is held. The newest held result is loaded on the first falling host clock edge after 24 or more edges, so the word being read is never mixed.
- R11: The shared output reacts to a host clock transition on the third system clock edge after the pin changes.
- R12: Host clock edges while no result is pending, and results that arrive during sleep, do not change the shared output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| res_data | input | 24 | Conversion result, two's complement |
| res_valid | input | 1 | One-cycle strobe marking `res_data` valid |
| sleep_limit | input | 16 | System clocks of continuous high host clock that mean sleep (at least 2) |
| rdy_dout | output | 1 | Shared ready flag (low) and serial data |
| sleep_o | output | 1 | High while the converter is asleep |
| cal_req_o | output | 1 | One-cycle self-calibration request |
| conv_restart_o | output | 1 | One-cycle conversion restart after wake-up |

## Verification
The collision that matters is a new result strobe landing in the same system clock as a synchronised rising edge of the host clock. The edge must shift the old word, and the strobe must be held, not loaded. The bench sweeps the strobe across several cycle offsets around the first read edge of a word, so it falls before, on and after the edge cycle. A behavioural model decides each cycle whether the result is loaded at once or held and delivered after the 24th falling edge, and the shared output is compared against the model on every system clock.

// File: rtl/twowire_adc_link.sv
module twowire_adc_link #(
  parameter int DW = 24,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  input  logic [DW-1:0] res_data,
  input  logic          res_valid,
  input  logic [LW-1:0] sleep_limit,
  output logic          rdy_dout,
  output logic          sleep_o,
  output logic          cal_req_o,
  output logic          conv_restart_o
);

  localparam int CW = $clog2(DW + 3);
  localparam logic [CW-1:0] N_LAST = CW'(DW);
  localparam logic [CW-1:0] N_CAL  = CW'(DW + 2);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_SLEEP} st_t;

  st_t           st;
  logic          s1, s2, s3;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg, pend;
  logic          pend_v, wake_cal, dout;
  logic [LW-1:0] hcnt;

  wire rise      = s2 & ~s3;
  wire fall      = ~s2 & s3;
  wire sleep_hit = (st == S_READ) && s2 &&
                   ({1'b0, hcnt} + 1'b1 >= {1'b0, sleep_limit});
  wire mid_read  = rise || (cnt != '0 && cnt < N_LAST);

  assign rdy_dout = dout;
  assign sleep_o  = (st == S_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= sclk_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= '0;
    else if (st == S_READ && s2) hcnt <= hcnt + 1'b1;
    else hcnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= S_IDLE;
      dout           <= 1'b1;
      cnt            <= '0;
      shreg          <= '0;
      pend           <= '0;
      pend_v         <= 1'b0;
      wake_cal       <= 1'b0;
      cal_req_o      <= 1'b0;
      conv_restart_o <= 1'b0;
    end else begin
      cal_req_o      <= 1'b0;
      conv_restart_o <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (res_valid) begin
            shreg  <= res_data;
            dout   <= 1'b0;
            cnt    <= '0;
            pend_v <= 1'b0;
            st     <= S_READ;
          end
        end
        S_READ: begin
          if (sleep_hit) begin
            st       <= S_SLEEP;
            dout     <= 1'b1;
            wake_cal <= (cnt == N_CAL);
            pend_v   <= 1'b0;
          end else if (fall && cnt == N_CAL) begin
            cal_req_o <= 1'b1;
            pend_v    <= 1'b0;
            st        <= S_IDLE;
          end else begin
            if (rise) begin
              if (cnt != N_CAL) cnt <= cnt + 1'b1;
              if (cnt < N_LAST) begin
                dout  <= shreg[DW-1];
                shreg <= shreg << 1;
              end else begin
                dout <= 1'b1;
              end
            end
            if (res_valid) begin
              if (mid_read) begin
                pend   <= res_data;
                pend_v <= 1'b1;
              end else begin
                shreg  <= res_data;
                dout   <= 1'b0;
                cnt    <= '0;
                pend_v <= 1'b0;
              end
            end else if (fall && pend_v && cnt >= N_LAST) begin
              shreg  <= pend;
              dout   <= 1'b0;
              cnt    <= '0;
              pend_v <= 1'b0;
            end
          end
        end
        S_SLEEP: begin
          if (fall) begin
            st <= S_IDLE;
            if (wake_cal) cal_req_o <= 1'b1;
            else conv_restart_o <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_load_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && res_valid) |=> !rdy_dout);

  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && !rise && !fall && !res_valid && !sleep_hit) |=> $stable(rdy_dout));

  assert_release_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_READ && rise && cnt == N_LAST && !sleep_hit && !res_valid) |=> rdy_dout);

  assert_cal_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |=> !cal_req_o);

  assert_sleep_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> rdy_dout);

  assert_wake_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> ($countones({cal_req_o, conv_restart_o}) == 1));

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_req_o, conv_restart_o}));

endmodule

// File: tb/twowire_adc_link_tb.sv
`timescale 1ns/1ps
module twowire_adc_link_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0;
  logic [23:0] res_data = '0;
  logic        res_valid = 1'b0;
  logic [15:0] sleep_limit = 16'd40;
  logic        rdy_dout, sleep_o, cal_req_o, conv_restart_o;

  int checks = 0;
  int failures = 0;
  int n_cal = 0;
  int n_rs = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  twowire_adc_link u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .res_data(res_data),
    .res_valid(res_valid), .sleep_limit(sleep_limit), .rdy_dout(rdy_dout),
    .sleep_o(sleep_o), .cal_req_o(cal_req_o), .conv_restart_o(conv_restart_o)
  );

  // behavioural reference: 0 idle, 1 reading, 2 asleep
  int          m_st, m_cnt, m_hi, m_nhi;
  bit          m_dout, m_cal, m_rs, m_pv, m_wcal;
  bit [23:0]   m_word, m_pend;
  bit          q1, q2, q3, m_r, m_f, m_hit, m_mid;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_hi = 0; m_dout = 1; m_cal = 0; m_rs = 0;
      m_pv = 0; m_wcal = 0; m_word = '0; m_pend = '0; q1 = 0; q2 = 0; q3 = 0;
    end else begin
      m_r = q2 && !q3;
      m_f = !q2 && q3;
      m_cal = 0; m_rs = 0;
      m_hit = (m_st == 1) && q2 && (m_hi + 1 >= int'(sleep_limit));
      m_nhi = (m_st == 1 && q2) ? m_hi + 1 : 0;
      if (m_st == 0) begin
        if (res_valid) begin m_word = res_data; m_dout = 0; m_cnt = 0; m_pv = 0; m_st = 1; end
      end else if (m_st == 1) begin
        m_mid = m_r || (m_cnt > 0 && m_cnt < 24);
        if (m_hit) begin
          m_st = 2; m_dout = 1; m_wcal = (m_cnt == 26); m_pv = 0;
        end else if (m_f && m_cnt == 26) begin
          m_cal = 1; m_pv = 0; m_st = 0;
        end else begin
          if (m_r) begin
            m_dout = (m_cnt < 24) ? m_word[23 - m_cnt] : 1'b1;
            if (m_cnt < 26) m_cnt++;
          end
          if (res_valid) begin
            if (m_mid) begin m_pend = res_data; m_pv = 1; end
            else begin m_word = res_data; m_dout = 0; m_cnt = 0; m_pv = 0; end
          end else if (m_f && m_pv && m_cnt >= 24) begin
            m_word = m_pend; m_dout = 0; m_cnt = 0; m_pv = 0;
          end
        end
      end else begin
        if (m_f) begin
          m_st = 0;
          if (m_wcal) m_cal = 1; else m_rs = 1;
        end
      end
      m_hi = m_nhi;
      q3 = q2; q2 = q1; q1 = sclk_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({rdy_dout, sleep_o, cal_req_o, conv_restart_o} !==
          {m_dout, (m_st == 2), m_cal, m_rs}) begin
        failures++;
        $display("FAIL %s cycle compare: actual=%b expected=%b", cur_req,
                 {rdy_dout, sleep_o, cal_req_o, conv_restart_o},
                 {m_dout, (m_st == 2), m_cal, m_rs});
      end
      if (cal_req_o) n_cal++;
      if (conv_restart_o) n_rs++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give(logic [23:0] d);
    res_data = d; res_valid = 1'b1; tick(1); res_valid = 1'b0;
  endtask

  task automatic pulse();
    sclk_in = 1'b1; tick(6); sclk_in = 1'b0; tick(6);
  endtask

  task automatic read_bits(int n, output logic [23:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sclk_in = 1'b1; tick(5); got = {got[22:0], rdy_dout}; tick(1);
      sclk_in = 1'b0; tick(6);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [23:0] got, got2;
    int c0, r0;
    tick(3);
    check(rdy_dout === 1'b1 && sleep_o === 1'b0 && !cal_req_o && !conv_restart_o,
          "R1 reset state", {rdy_dout, sleep_o}, 2'b10);
    rst_n = 1'b1;
    tick(2);

    cur_req = "R12";
    pulse(); pulse();
    check(rdy_dout === 1'b1, "R12 idle edges ignored", rdy_dout, 1);

    cur_req = "R2";
    give(24'hA5C396);
    check(rdy_dout === 1'b0, "R2 ready low", rdy_dout, 0);

    cur_req = "R11";
    sclk_in = 1'b1; tick(2);
    check(rdy_dout === 1'b0, "R11 no change before third edge", rdy_dout, 0);
    tick(1);
    check(rdy_dout === 1'b1, "R11 bit 23 on third edge", rdy_dout, 1);
    tick(3); sclk_in = 1'b0; tick(6);

    cur_req = "R3";
    read_bits(23, got);
    check(got[22:0] === 23'h25C396, "R3 msb-first bits", got[22:0], 23'h25C396);
    cur_req = "R4";
    tick(6);
    check(rdy_dout === 1'b0, "R4 holds bit 0", rdy_dout, 0);
    pulse();
    check(rdy_dout === 1'b1, "R4 25th edge high", rdy_dout, 1);

    cur_req = "R9";
    give(24'h111111); tick(3); give(24'h7E0F31);
    read_bits(24, got);
    check(got === 24'h7E0F31, "R9 newer result replaces unread", got, 24'h7E0F31);
    pulse();

    cur_req = "R5";
    c0 = n_cal;
    give(24'h000001);
    for (int i = 0; i < 26; i++) pulse();
    tick(2);
    check(n_cal == c0 + 1, "R5 one calibration pulse", n_cal - c0, 1);
    check(rdy_dout === 1'b1, "R5 output high after request", rdy_dout, 1);

    cur_req = "R10";
    give(24'hC3A50F);
    read_bits(5, got);
    give(24'h123456); tick(2); give(24'h89ABCD);
    read_bits(19, got2);
    check({got[4:0], got2[18:0]} === 24'hC3A50F, "R10 held word not torn",
          {got[4:0], got2[18:0]}, 24'hC3A50F);
    tick(1);
    check(rdy_dout === 1'b0, "R10 held result delivered", rdy_dout, 0);
    read_bits(24, got);
    check(got === 24'h89ABCD, "R10 newest held result", got, 24'h89ABCD);

    cur_req = "R6";
    r0 = n_rs;
    sclk_in = 1'b1; tick(60);
    check(sleep_o === 1'b1 && rdy_dout === 1'b1, "R6 sleep entered", {sleep_o, rdy_dout}, 2'b11);
    cur_req = "R12";
    give(24'h555555); tick(2);
    check(rdy_dout === 1'b1, "R12 result dropped in sleep", rdy_dout, 1);
    cur_req = "R7";
    sclk_in = 1'b0; tick(6);
    check(sleep_o === 1'b0 && n_rs == r0 + 1, "R7 wake restart", n_rs - r0, 1);
    check(rdy_dout === 1'b1, "R7 high until next result", rdy_dout, 1);
    give(24'h0F0F0F);
    check(rdy_dout === 1'b0, "R7 next result low", rdy_dout, 0);

    cur_req = "R8";
    c0 = n_cal; r0 = n_rs;
    for (int i = 0; i < 25; i++) pulse();
    sclk_in = 1'b1; tick(60);
    check(sleep_o === 1'b1, "R8 sleep after 26th", sleep_o, 1);
    sclk_in = 1'b0; tick(6);
    check(n_cal == c0 + 1 && n_rs == r0, "R8 wake calibrates", n_cal - c0, 1);

    cur_req = "R10";
    for (int k = 0; k < 5; k++) begin
      give(24'h9C0000 | 24'(k));
      sclk_in = 1'b1; tick(k); give(24'h3B0000 | 24'(k)); tick(5 - k);
      sclk_in = 1'b0; tick(6);
      read_bits(23, got);
      sclk_in = 1'b1; tick(60); sclk_in = 1'b0; tick(6);
    end

    tick(4);
    finish_run();
  end

endmodule